// File: doc/BRIEF.md
# Power-on strap configuration latch

This block reads six dual-purpose strap pads exactly once, after a true power-on, and holds what it read in a read-only configuration word. A settle counter runs for a set number of clocks after the power-on reset lets go, then the pads are registered in a single edge. From then on, the block decodes three fields from the held word:

- the link type of the two permanent ports,
- the select for the auxiliary clock output that shares data pin 7,
- the transmit delay for the MII TX enable and data nibble.

Once the straps are held, the shared pads return to their working roles. The four low pads become LED outputs. Their polarity is inverted wherever the held strap is 1, so an active LED pulls against its strap resistor. The two high pads become outputs only when one of the ports is MII, where they carry the upper TX data bits.

A warm reset never resamples the straps and never drops the output drivers. While it is held, the LED pads show their inactive level. A reserved port-mode code raises a sticky error flag, and the ports are then treated as backplane type. Only a new power-on reset clears the held word and the error flag.

Top module: `strap_cfg_latch`

## Requirements
- R1: After porRst_n rises, the pads are captured on the SETTLE_CYC-th rising clock edge and cfgValid rises with that edge. Before that edge, cfgValid, cfgReg and padOe are all zero.
- R2: After capture, later changes on strapPad have no effect on cfgReg or on any decoded output.
- R3: While warmRst_n is low, and after it returns high, cfgReg, cfgValid, padOe and the decoded outputs keep their values. Warm reset does not resample the straps.
- R4: cfgReg bits [1:0] hold pads 1:0 (port mode), bits [3:2] hold pads 3:2 (clock-output mode), and bits [5:4] hold pads 5:4 (TX shift). Bits 7:6 read as zero.
- R5: portMii bit 0 is set when port 0 is MII and bit 1 is set when port 1 is MII. Port mode 00 gives 00, mode 10 gives 01 and mode 11 gives 10.
- R6: Port mode 01 is reserved. It gives portMii = 00 and sets configError, which stays set through warm resets until the next power-on reset.
- R7: Clock-output mode 00 gives clkOutEn = 0, clkDivRatio = 0, and data pin 7 stays free. Modes 01, 10 and 11 set clkOutEn, which marks pin 7 as taken by the clock, and give clkDivRatio 4, 5 and 10 (25, 20 and 10 MHz from 100 MHz).
- R8: txDelayCycles equals the TX shift field (0 to 3 cycles of 10 ns).
- R9: After capture, padOe[3:0] = 1111. padOe[5:4] = 11 only when portMii is non-zero, and 00 otherwise.
- R10: With cfgValid high and warmRst_n high, ledDrive[i] = ledReq[i] XOR cfgReg[i]. While warmRst_n is low, ledDrive[i] = cfgReg[i] (LED off). Before capture, ledDrive is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRst_n | input | 1 | Power-on reset, active low, asynchronous |
| warmRst_n | input | 1 | Warm reset, active low |
| strapPad | input | 6 | Strap pad input values |
| ledReq | input | 4 | LED-on requests for the four LED pads |
| cfgReg | output | 8 | Read-only configuration word |
| cfgValid | output | 1 | Straps have been captured |
| padOe | output | 6 | Output enables of the shared pads |
| portMii | output | 2 | Per-port MII selected |
| configError | output | 1 | Sticky flag for the reserved port mode |
| clkOutEn | output | 1 | Clock output active; pin 7 taken from data use |
| clkDivRatio | output | 4 | Divide ratio for the clock output (0 when off) |
| txDelayCycles | output | 2 | TX pipeline delay in clock cycles |
| ledDrive | output | 4 | Levels driven on the LED pads |

## Verification
The capture happens on the SETTLE_CYC-th rising edge after power-on reset release. The bench therefore checks that nothing is valid after SETTLE_CYC-1 edges, sets the final pad value in that last cycle, and checks the captured outputs one edge later. It also changes the pad value earlier in the settle window to show that the earlier value is discarded.

All decoded outputs and pad enables are combinational from the held word, so they are due in the same cycle as cfgValid. ledDrive follows ledReq and warmRst_n with no delay. Each of these is compared at the falling edge after the stimulus, against an expected record that the driver pushed into the scoreboard queue.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  typedef enum logic [1:0] {
    PH_HOLD   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DONE   = 2'd2
  } strapPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register the pads this edge
    logic ledBlank;  // warm reset active: LEDs to inactive level
  } strapStb_t;

  localparam logic [1:0] MODE_BOTH_BP  = 2'b00;
  localparam logic [1:0] MODE_RESERVED = 2'b01;
  localparam logic [1:0] MODE_P0_MII   = 2'b10;
  localparam logic [1:0] MODE_P1_MII   = 2'b11;

endpackage

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic      clk,
  input  logic      porRst_n,
  input  logic      warmRst_n,
  output strapStb_t stb
);

  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

  strapPhase_t phase;
  logic [CNT_W-1:0] settleCnt;
  logic lastSettle;

  assign lastSettle = (settleCnt == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      phase     <= PH_HOLD;
      settleCnt <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          if (SETTLE_CYC <= 1) phase <= PH_DONE;
          else begin
            phase     <= PH_SETTLE;
            settleCnt <= CNT_W'(1);
          end
        end
        PH_SETTLE: begin
          if (lastSettle) phase <= PH_DONE;
          else settleCnt <= settleCnt + CNT_W'(1);
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    stb.capture  = 1'b0;
    stb.ledBlank = !warmRst_n;
    if (phase == PH_HOLD && SETTLE_CYC <= 1) stb.capture = 1'b1;
    if (phase == PH_SETTLE && lastSettle)    stb.capture = 1'b1;
  end

  // one capture strobe per power-on
  assert_single_capture_R1: assert property (@(posedge clk) disable iff (!porRst_n)
    stb.capture |=> (phase == PH_DONE) && !stb.capture);

  assert_done_is_final_R3: assert property (@(posedge clk) disable iff (!porRst_n)
    (phase == PH_DONE) |=> (phase == PH_DONE));

endmodule

// File: rtl/strap_cfg_datapath.sv
module strap_cfg_datapath
  import strap_cfg_pkg::*;
#(
  parameter int STRAP_N       = 6,
  parameter int LED_N         = 4,
  parameter int REG_W         = 8,
  parameter int CORE_MHZ      = 100,
  parameter int DIV_W         = 4,
  parameter int DLY_W         = 2,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SHIFT_STEP_NS = 10
) (
  input  logic               clk,
  input  logic               porRst_n,
  input  strapStb_t          stb,
  input  logic [STRAP_N-1:0] strapPad,
  input  logic [LED_N-1:0]   ledReq,
  output logic [REG_W-1:0]   cfgReg,
  output logic               cfgValid,
  output logic [STRAP_N-1:0] padOe,
  output logic [1:0]         portMii,
  output logic               configError,
  output logic               clkOutEn,
  output logic [DIV_W-1:0]   clkDivRatio,
  output logic [DLY_W-1:0]   txDelayCycles,
  output logic [LED_N-1:0]   ledDrive
);

  localparam int DIV_HI    = CORE_MHZ / 25;
  localparam int DIV_MID   = CORE_MHZ / 20;
  localparam int DIV_LO    = CORE_MHZ / 10;
  localparam int STEP_CYC  = SHIFT_STEP_NS / CLK_PERIOD_NS;

  logic [STRAP_N-1:0] strapHeld;
  logic [1:0] portMode, clkMode, txShift;

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      strapHeld   <= '0;
      cfgValid    <= 1'b0;
      configError <= 1'b0;
    end else if (stb.capture) begin
      strapHeld   <= strapPad;
      cfgValid    <= 1'b1;
      configError <= (strapPad[1:0] == MODE_RESERVED);
    end
  end

  assign portMode = strapHeld[1:0];
  assign clkMode  = strapHeld[3:2];
  assign txShift  = strapHeld[5:4];

  generate
    if (REG_W > STRAP_N) begin : g_pad_reg
      assign cfgReg = {{(REG_W-STRAP_N){1'b0}}, strapHeld};
    end else begin : g_flat_reg
      assign cfgReg = strapHeld[REG_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (portMode)
      MODE_P0_MII: portMii = 2'b01;
      MODE_P1_MII: portMii = 2'b10;
      default:     portMii = 2'b00;
    endcase
  end

  always_comb begin
    clkOutEn = (clkMode != 2'b00);
    unique case (clkMode)
      2'b01:   clkDivRatio = DIV_W'(DIV_HI);
      2'b10:   clkDivRatio = DIV_W'(DIV_MID);
      2'b11:   clkDivRatio = DIV_W'(DIV_LO);
      default: clkDivRatio = '0;
    endcase
  end

  assign txDelayCycles = DLY_W'(int'(txShift) * STEP_CYC);

  // per-pin direction and LED polarity
  generate
    for (genvar p = 0; p < STRAP_N; p++) begin : g_pin
      if (p < LED_N) begin : g_led
        assign padOe[p] = cfgValid;
        assign ledDrive[p] = !cfgValid    ? 1'b0 :
                             stb.ledBlank ? strapHeld[p] :
                                            (ledReq[p] ^ strapHeld[p]);
      end else begin : g_tx
        assign padOe[p] = cfgValid && (portMii != 2'b00);
      end
    end
  endgenerate

  assert_no_resample_R2: assert property (@(posedge clk) disable iff (!porRst_n)
    cfgValid |=> $stable(cfgReg) && cfgValid);

  assert_quiet_before_capture_R1: assert property (@(posedge clk) disable iff (!porRst_n)
    !cfgValid |-> (padOe == '0) && (cfgReg == '0));

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!porRst_n)
    configError |=> configError);

  assert_reserved_backplane_R6: assert property (@(posedge clk) disable iff (!porRst_n)
    configError |-> (portMii == 2'b00));

  assert_clk_ratio_R7: assert property (@(posedge clk) disable iff (!porRst_n)
    clkOutEn |-> (clkDivRatio != '0));

  assert_led_blank_R10: assert property (@(posedge clk) disable iff (!porRst_n)
    (cfgValid && stb.ledBlank) |-> (ledDrive == strapHeld[LED_N-1:0]));

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int CORE_MHZ   = 100
) (
  input  logic       clk,
  input  logic       porRst_n,
  input  logic       warmRst_n,
  input  logic [5:0] strapPad,
  input  logic [3:0] ledReq,
  output logic [7:0] cfgReg,
  output logic       cfgValid,
  output logic [5:0] padOe,
  output logic [1:0] portMii,
  output logic       configError,
  output logic       clkOutEn,
  output logic [3:0] clkDivRatio,
  output logic [1:0] txDelayCycles,
  output logic [3:0] ledDrive
);

  strapStb_t stb;

  strap_cfg_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk       (clk),
    .porRst_n  (porRst_n),
    .warmRst_n (warmRst_n),
    .stb       (stb)
  );

  strap_cfg_datapath #(
    .STRAP_N (6), .LED_N (4), .REG_W (8), .CORE_MHZ (CORE_MHZ),
    .DIV_W (4), .DLY_W (2), .CLK_PERIOD_NS (1000 / CORE_MHZ), .SHIFT_STEP_NS (10)
  ) u_dp (
    .clk           (clk),
    .porRst_n      (porRst_n),
    .stb           (stb),
    .strapPad      (strapPad),
    .ledReq        (ledReq),
    .cfgReg        (cfgReg),
    .cfgValid      (cfgValid),
    .padOe         (padOe),
    .portMii       (portMii),
    .configError   (configError),
    .clkOutEn      (clkOutEn),
    .clkDivRatio   (clkDivRatio),
    .txDelayCycles (txDelayCycles),
    .ledDrive      (ledDrive)
  );

endmodule

// File: tb/strap_cfg_latch_test.sv
module strap_cfg_latch_test;

  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic porRst_n = 1'b0;
  logic warmRst_n = 1'b1;
  logic [5:0] strapPad = '0;
  logic [3:0] ledReq = '0;
  logic [7:0] cfgReg;
  logic cfgValid, configError, clkOutEn;
  logic [5:0] padOe;
  logic [1:0] portMii, txDelayCycles;
  logic [3:0] clkDivRatio, ledDrive;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strap_cfg_latch #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .porRst_n(porRst_n), .warmRst_n(warmRst_n), .strapPad(strapPad),
    .ledReq(ledReq), .cfgReg(cfgReg), .cfgValid(cfgValid), .padOe(padOe),
    .portMii(portMii), .configError(configError), .clkOutEn(clkOutEn),
    .clkDivRatio(clkDivRatio), .txDelayCycles(txDelayCycles), .ledDrive(ledDrive)
  );

  typedef struct {
    string      tag;
    logic       valid;
    logic [7:0] reg8;
    logic [5:0] oe;
    logic [1:0] mii;
    logic       err;
    logic       clkEn;
    logic [3:0] div;
    logic [1:0] dly;
    logic [3:0] led;
  } expect_t;

  expect_t sbq[$];
  event checkEv;

  // expected values from the requirement text
  function automatic expect_t model(string tag, logic valid, logic [5:0] held,
                                    logic err, logic [3:0] req, logic warm);
    expect_t e;
    e.tag = tag;
    e.valid = valid;
    e.reg8 = valid ? {2'b00, held} : 8'h00;
    e.err = err;
    case (held[1:0])
      2'b10: e.mii = 2'b01;
      2'b11: e.mii = 2'b10;
      default: e.mii = 2'b00;
    endcase
    case (held[3:2])
      2'b01: e.div = 4'd4;
      2'b10: e.div = 4'd5;
      2'b11: e.div = 4'd10;
      default: e.div = 4'd0;
    endcase
    e.clkEn = (held[3:2] != 2'b00);
    e.dly = held[5:4];
    e.oe = {(e.mii != 2'b00) ? 2'b11 : 2'b00, 4'hF};
    e.led = warm ? (req ^ held[3:0]) : held[3:0];
    if (!valid) begin
      e.mii = 0; e.div = 0; e.clkEn = 0; e.dly = 0; e.oe = 0; e.led = 0;
    end
    return e;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      expect_t e;
      @(checkEv);
      e = sbq.pop_front();
      cmp({e.tag, " valid"}, int'(cfgValid), int'(e.valid));
      cmp({e.tag, " cfgReg R4"}, int'(cfgReg), int'(e.reg8));
      cmp({e.tag, " padOe R9"}, int'(padOe), int'(e.oe));
      cmp({e.tag, " portMii R5"}, int'(portMii), int'(e.mii));
      cmp({e.tag, " configError R6"}, int'(configError), int'(e.err));
      cmp({e.tag, " clkOutEn R7"}, int'(clkOutEn), int'(e.clkEn));
      cmp({e.tag, " clkDivRatio R7"}, int'(clkDivRatio), int'(e.div));
      cmp({e.tag, " txDelay R8"}, int'(txDelayCycles), int'(e.dly));
      cmp({e.tag, " ledDrive R10"}, int'(ledDrive), int'(e.led));
    end
  end

  task automatic expectNow(expect_t e);
    sbq.push_back(e);
    -> checkEv;
    #1;
  endtask

  // full power-on: early pad value changed to final one in the last settle cycle
  task automatic powerOn(logic [5:0] early, logic [5:0] final_v, logic [3:0] req);
    @(negedge clk);
    porRst_n = 1'b0;
    ledReq = 4'h0;
    strapPad = early;
    @(negedge clk);
    porRst_n = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    expectNow(model("R1 pre-capture", 1'b0, 6'h0, 1'b0, 4'h0, 1'b1));
    strapPad = final_v;
    @(negedge clk);
    strapPad = ~final_v;   // R2: later pad changes are ignored
    ledReq = req;
    #1;
    expectNow(model("R1 capture", 1'b1, final_v, final_v[1:0] == 2'b01, req, 1'b1));
  endtask

  task automatic warmPulse(logic [5:0] held, logic [3:0] req);
    @(negedge clk);
    warmRst_n = 1'b0;
    #1;
    expectNow(model("R3 in warm reset", 1'b1, held, held[1:0] == 2'b01, req, 1'b0));
    repeat (3) @(negedge clk);
    warmRst_n = 1'b1;
    @(negedge clk);
    expectNow(model("R3 after warm reset", 1'b1, held, held[1:0] == 2'b01, req, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expectNow(model("R1 reset state", 1'b0, 6'h0, 1'b0, 4'h0, 1'b1));

    // port0 MII, 20 MHz, shift 1
    powerOn(6'b11_01_11, 6'b01_10_10, 4'b1010);
    repeat (4) @(negedge clk);
    expectNow(model("R2 no resample", 1'b1, 6'b01_10_10, 1'b0, 4'b1010, 1'b1));
    warmPulse(6'b01_10_10, 4'b1010);

    // port1 MII, clock off, shift 3
    powerOn(6'b00_00_00, 6'b11_00_11, 4'b1111);
    ledReq = 4'b0000;
    #1;
    expectNow(model("R10 led off", 1'b1, 6'b11_00_11, 1'b0, 4'b0000, 1'b1));

    // reserved port mode, 25 MHz, shift 2
    powerOn(6'b00_00_00, 6'b10_01_01, 4'b0101);
    warmPulse(6'b10_01_01, 4'b0101);

    // both backplane, 10 MHz, shift 0: error cleared by new power-on
    powerOn(6'b11_11_01, 6'b00_11_00, 4'b0011);
    warmPulse(6'b00_11_00, 4'b0011);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule